// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Selectable Deselect Timing

A behavioural, synthesizable single-port synchronous SRAM. Its inputs are registered, and its read path is two stages deep. Address, write data, chip enable and write controls are captured on a rising clock edge. The word read for a captured read command appears on the data outputs after the second rising edge that follows the capture. An external burst sequencer supplies the address on every cycle, so the block has no address counter of its own.

Writes take effect one cycle after capture. A write may cover selected bytes, using a byte-write enable together with active-low per-byte strobes. It may instead cover the whole word through a global write, which overrides the byte controls.

A mode pin sets when the output drivers turn off after a deselect. In dual-cycle mode the deselect travels as deep as a read. In single-cycle mode it is one stage shallower, so it cuts short the output of a read that was captured just before it. Two asynchronous inputs act without a clock: an output enable that gates the data outputs, and a sleep input that blocks all accesses and forces the outputs off. Sleep keeps the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, and before any read command, dq_drive is 0 and dq_out is 0.
- R2: A read captured at edge k, with ce_n low, gw_n high, bwe_n high and sleep low, presents the addressed word on dq_out with dq_drive high after edge k+2. This holds when oe_n and sleep are low and no single-cycle cut applies.
- R3: With scd_mode low (dual-cycle deselect), whether the outputs drive after edge k+2 depends only on the command captured at edge k. A deselect captured at edge k+1 does not shorten it.
- R4: With scd_mode high (single-cycle deselect), a deselect captured at edge k+1 turns the outputs off after edge k+2, even when edge k captured a read. A deselect is a capture with ce_n high or sleep high.
- R5: With gw_n high and bwe_n low, byte i (bits 8i+7 down to 8i) of the addressed word takes din when bs_n bit i is low, and keeps its value when that bit is high. With all strobes high, memory is unchanged and the cycle is not a read.
- R6: With gw_n low, the whole addressed word takes din, whatever bwe_n and bs_n hold.
- R7: A cycle captured with ce_n high neither writes memory nor produces read data.
- R8: While sleep is high, dq_drive and dq_out are 0 at once, without a clock edge. Commands captured with sleep high have no effect, and stored contents are retained.
- R9: While oe_n is high, dq_drive and dq_out are 0 at once, without a clock edge. dq_out is 0 whenever dq_drive is 0.
- R10: Write cycles never drive the outputs. A read captured on the edge right after a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers (memory contents not cleared) |
| ce_n | input | 1 | Active-low chip enable, registered |
| adr | input | ADDR_W | Word address from the external burst sequencer, registered |
| din | input | 8*BYTE_N | Write data, registered |
| bwe_n | input | 1 | Active-low byte-write enable |
| bs_n | input | BYTE_N | Active-low byte strobes, bit i selects byte i |
| gw_n | input | 1 | Active-low global write, overrides the byte controls |
| scd_mode | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| sleep | input | 1 | Asynchronous sleep; blocks accesses, outputs off |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 8*BYTE_N | Read data, 0 when not driving |
| dq_drive | output | 1 | High when the data outputs are driven |

## Verification
The assertions assume that scd_mode is quasi-static. It may change only while no read is in flight, because the single-cycle cut samples it at the edge where the drive register loads. They also assume that sleep and oe_n change away from the rising edge. The stimulus changes every input only on the falling clock edge, flips scd_mode only after idle cycles, and pulses sleep and oe_n briefly in mid-cycle when testing asynchronous gating. Those pulses are released well before the next rising edge. All sixteen words of a reduced configuration are swept with global and byte writes, including every strobe pattern. A pseudo-random mix of commands follows in each deselect mode.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic [ADDR_W-1:0]     adr,
  input  logic [8*BYTE_N-1:0]   din,
  input  logic                  bwe_n,
  input  logic [BYTE_N-1:0]     bs_n,
  input  logic                  gw_n,
  input  logic                  scd_mode,
  input  logic                  sleep,
  input  logic                  oe_n,
  output logic [8*BYTE_N-1:0]   dq_out,
  output logic                  dq_drive
);
  localparam int DATA_W = 8 * BYTE_N;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              sel_in, wr_in;
  logic [BYTE_N-1:0] mask_in;

  logic              rd0, wr0, ds0, rd1, wr1, drv_q;
  logic [BYTE_N-1:0] mask0;
  logic [ADDR_W-1:0] adr0;
  logic [DATA_W-1:0] din0, mdata, dout_q;

  assign sel_in  = !ce_n && !sleep;
  assign wr_in   = sel_in && (!gw_n || !bwe_n);
  assign mask_in = !gw_n ? '1 : (!bwe_n ? ~bs_n : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd0    <= 1'b0;
      wr0    <= 1'b0;
      ds0    <= 1'b1;
      rd1    <= 1'b0;
      wr1    <= 1'b0;
      drv_q  <= 1'b0;
      mask0  <= '0;
      adr0   <= '0;
      din0   <= '0;
      mdata  <= '0;
      dout_q <= '0;
    end else begin
      rd0    <= sel_in && !wr_in;
      wr0    <= wr_in;
      ds0    <= !sel_in;
      mask0  <= mask_in;
      adr0   <= adr;
      din0   <= din;
      rd1    <= rd0;
      wr1    <= wr0;
      mdata  <= mem[adr0];
      dout_q <= mdata;
      drv_q  <= rd1 && !(scd_mode && ds0);
    end
  end

  always_ff @(posedge clk) begin
    if (wr0) begin
      for (int b = 0; b < BYTE_N; b++) begin
        if (mask0[b]) mem[adr0][8*b +: 8] <= din0[8*b +: 8];
      end
    end
  end

  assign dq_drive = drv_q && !oe_n && !sleep;
  assign dq_out   = dq_drive ? dout_q : '0;

  assert_drive_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> $past(rd1));

  assert_dual_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scd_mode) && $past(rd1)) |-> drv_q);

  assert_single_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scd_mode) && $past(ds0)) |-> !drv_q);

  assert_sleep_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> (!rd0 && !wr0));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_drive && dq_out == '0));

  assert_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr1) |-> !drv_q);
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int BN = 2;
  localparam int DW = 8 * BN;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, bwe_n = 1'b1, gw_n = 1'b1;
  logic          scd_mode = 1'b0, sleep = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] din = '0;
  logic [BN-1:0] bs_n = '1;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit probe  = 0;

  logic [DW-1:0] model [NW];
  logic          h1_rd = 0, h2_rd = 0, h3_rd = 0;
  logic          h1_ds = 1, h2_ds = 1, h3_ds = 1;
  logic [DW-1:0] h1_v = '0, h2_v = '0, h3_v = '0;
  logic [15:0]   lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .BYTE_N(BN)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adr(adr), .din(din),
    .bwe_n(bwe_n), .bs_n(bs_n), .gw_n(gw_n), .scd_mode(scd_mode),
    .sleep(sleep), .oe_n(oe_n), .dq_out(dq_out), .dq_drive(dq_drive));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out(input string tag);
    logic edrv;
    edrv = h3_rd && !(scd_mode && h2_ds) && !oe_n && !sleep;
    chk({tag, " drive"}, DW'(dq_drive), DW'(edrv));
    chk({tag, " data"}, dq_out, edrv ? h3_v : '0);
    if (probe && edrv) begin
      oe_n = 1'b1; #1;
      chk("R9 async oe drive", DW'(dq_drive), '0);
      chk("R9 async oe data", dq_out, '0);
      oe_n = 1'b0; #1;
      sleep = 1'b1; #1;
      chk("R8 async sleep drive", DW'(dq_drive), '0);
      chk("R8 async sleep data", dq_out, '0);
      sleep = 1'b0; #1;
      chk("R9 restore data", dq_out, h3_v);
    end
  endtask

  task automatic step(input logic ce_v, input logic gw_v, input logic bwe_v,
                      input logic [BN-1:0] bs_v, input logic [AW-1:0] a_v,
                      input logic [DW-1:0] d_v, input logic slp_v, input logic oe_v,
                      input string tag);
    logic sel, isw, isr;
    @(negedge clk);
    check_out(tag);
    ce_n = ce_v; gw_n = gw_v; bwe_n = bwe_v; bs_n = bs_v;
    adr = a_v; din = d_v; sleep = slp_v; oe_n = oe_v;
    sel = !ce_v && !slp_v;
    isw = sel && (!gw_v || !bwe_v);
    isr = sel && !isw;
    h3_rd = h2_rd; h3_ds = h2_ds; h3_v = h2_v;
    h2_rd = h1_rd; h2_ds = h1_ds; h2_v = h1_v;
    h1_rd = isr; h1_ds = !sel; h1_v = isr ? model[a_v] : '0;
    if (isw)
      for (int b = 0; b < BN; b++)
        if (!gw_v || !bs_v[b]) model[a_v][8*b +: 8] = d_v[8*b +: 8];
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'b1, 1'b1, '1, a, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) idle(tag);
  endtask

  task automatic random_mix(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d = lf ^ DW'(i * 16'h3b1);
      case (lf[2:0])
        3'd2:    step(1'b0, 1'b1, 1'b0, lf[5:4], lf[11:8], d, lf[15:12] == 0, 1'b0, tag);
        3'd3:    step(1'b0, 1'b0, lf[6], lf[5:4], lf[11:8], d, 1'b0, 1'b0, tag);
        3'd4:    idle(tag);
        3'd6:    step(1'b1, 1'b0, 1'b0, '0, lf[11:8], d, 1'b0, 1'b0, tag);
        3'd7:    step(1'b0, 1'b1, 1'b1, '1, lf[11:8], d, 1'b0, lf[7], tag);
        default: step(1'b0, 1'b1, 1'b1, '1, lf[11:8], d, lf[15:12] == 0, 1'b0, tag);
      endcase
    end
    flush(tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset drive", DW'(dq_drive), '0);
    chk("R1 reset data", dq_out, '0);
    flush("R1 idle after reset");

    // R6: global write overrides byte controls, half with all strobes off
    for (int a = 0; a < NW; a++)
      step(1'b0, 1'b0, a[0], a[1] ? '1 : '0, AW'(a), DW'(a * 16'h1357 ^ 16'hA5C3), 1'b0, 1'b0, "R6 global write");
    for (int a = 0; a < NW; a++) rd(AW'(a), "R6 readback");
    flush("R2 flush");

    // R5: every strobe pattern on every word
    for (int p = 0; p < (1 << BN); p++) begin
      for (int a = 0; a < NW; a++)
        step(1'b0, 1'b1, 1'b0, BN'(p ^ a), AW'(a), DW'((a + 7) * (p + 3) * 16'h0F1D), 1'b0, 1'b0, "R5 byte write");
      for (int a = 0; a < NW; a++) rd(AW'(a), "R5 readback");
      flush("R5 flush");
    end

    // R3: dual-cycle deselect, read/deselect alternation keeps output
    scd_mode = 1'b0;
    probe = 1;
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), "R3 read");
      idle("R3 deselect after read");
    end
    flush("R3 flush");
    probe = 0;

    // R4: single-cycle deselect cuts the output
    scd_mode = 1'b1;
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), "R4 read");
      idle("R4 deselect after read");
    end
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), "R4 read pair");
      rd(AW'(NW - 1 - a), "R4 read pair");
      step(1'b0, 1'b1, 1'b1, '1, '0, '0, 1'b1, 1'b0, "R4 sleep as deselect");
    end
    flush("R4 flush");

    // R10 in both modes: write then read same word
    for (int m = 0; m < 2; m++) begin
      scd_mode = m[0];
      for (int a = 0; a < NW; a++) begin
        step(1'b0, 1'b0, 1'b1, '1, AW'(a), DW'(16'hC0DE ^ (a << 4) ^ m), 1'b0, 1'b0, "R10 write");
        rd(AW'(a), "R10 read after write");
      end
      flush("R10 flush");
    end

    // R7: writes with chip enable off
    for (int a = 0; a < NW; a++)
      step(1'b1, 1'b0, 1'b0, '0, AW'(a), 16'hDEAD, 1'b0, 1'b0, "R7 deselected write");
    for (int a = 0; a < NW; a++) rd(AW'(a), "R7 readback");
    flush("R7 flush");

    // R8: accesses during sleep ignored, contents kept
    for (int a = 0; a < NW; a++)
      step(1'b0, 1'b0, 1'b0, '0, AW'(a), 16'hBEEF, 1'b1, 1'b0, "R8 write in sleep");
    for (int a = 0; a < NW; a++)
      step(1'b0, 1'b1, 1'b1, '1, AW'(a), '0, 1'b1, 1'b0, "R8 read in sleep");
    for (int a = 0; a < NW; a++) rd(AW'(a), "R8 readback");
    flush("R8 flush");

    // R9: output enable held high during reads
    for (int a = 0; a < NW; a++)
      step(1'b0, 1'b1, 1'b1, '1, AW'(a), '0, 1'b0, 1'b1, "R9 oe high");
    flush("R9 flush");

    scd_mode = 1'b0;
    random_mix(600, "R2 mix dual");
    scd_mode = 1'b1;
    random_mix(600, "R2 mix single");

    finish_run();
  end
endmodule